// File: doc/BRIEF.md
# SPI Burst Register Bridge

This block is an SPI mode 0 target that lets an external host read and write a byte-wide internal memory with a 16-bit address space. Each transaction is framed by chip select. It opens with a four-byte header that gives the start address, the transfer direction and a 15-bit byte count. A data phase of that many bytes follows. The address steps by one after every data byte, so a single frame can move up to 32767 consecutive bytes.

The SPI pins are sampled in the system clock domain through synchronizers. The serial clock must therefore stay at least four system clocks high and four low. On the internal side there is a synchronous memory port with single-cycle strobes. Read data is expected one cycle after the read strobe. For reads, the bridge fetches the first byte as soon as the header is complete. It fetches each later byte while the current one is still being shifted out, so the serial stream never waits.

Top module: `spi_burst_bridge`

## Requirements
- R1: Header byte order is address high byte, address low byte, control byte, count low byte. The control byte carries the direction in bit 7 (1 = write, 0 = read) and count bits 14:8 in bits 6:0.
- R2: A write frame of count N produces exactly N single-cycle `mem_wen` pulses, one per completed data byte, at consecutive addresses starting at the header address. `mem_wdata` carries the received byte, MSB first on the wire.
- R3: A read frame of count N issues exactly N `mem_ren` pulses at consecutive addresses. It returns those bytes on MISO, MSB first, with no gap between bytes.
- R4: A two-byte access is big-endian: the byte at the start address is the high byte and travels first.
- R5: The address wraps from 16'hFFFF to 16'h0000 within a frame.
- R6: Bytes clocked after the count is used up cause no memory strobe, and MISO stays 0 during them.
- R7: A frame with count 0 makes no memory access, whatever its direction.
- R8: Raising chip select ends the frame at once. Completed bytes stay written, a partial byte is discarded, and the next frame starts with a fresh header.
- R9: MOSI is sampled on rising SCLK. MISO changes only after falling SCLK or on deselect, and it reads 0 during the header and while chip select is high.
- R10: `mem_wen` and `mem_ren` are never asserted together, and each strobe lasts one cycle.
- R11: After reset, both memory strobes are low and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_wen | output | 1 | Single-cycle write strobe |
| mem_ren | output | 1 | Single-cycle read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_ren` |

## Verification
Two pairs of events can land in the same cycle. In a multi-byte read, the falling edge that loads the next byte into the output shifter also launches the prefetch of the byte after it. Long reads drive this case, and they pass only if every byte returns in order and the read-strobe count equals the frame count. The other pair is byte completion and deselect. The abort test drops chip select just after two whole bytes and three stray bits, then checks which memory locations changed and that a new header still decodes.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;
  localparam int ADDR_W    = 16;
  localparam int LEN_W     = 15;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 4;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam int HDR_IDX_W = $clog2(HDR_BYTES);

  typedef enum logic [1:0] {
    PH_HDR,
    PH_DATA,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/spi_brg_sync.sv
module spi_brg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  // one extra tap on the clock line gives the edge reference
  logic [STAGES:0]   sclk_p;
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] mosi_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[STAGES-1:0], sclk_i};
      cs_p   <= {cs_p[STAGES-2:0], cs_n_i};
      mosi_p <= {mosi_p[STAGES-2:0], mosi_i};
    end
  end

  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
  assign sclk_fall = ~sclk_p[STAGES-1] & sclk_p[STAGES];
  assign cs_act    = ~cs_p[STAGES-1];
  assign mosi_s    = mosi_p[STAGES-1];
endmodule

// File: rtl/spi_brg_shift.sv
module spi_brg_shift
  import spi_brg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              tx_take,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam logic [BIT_CNT_W-1:0] BIT_LAST = BIT_CNT_W'(BYTE_W - 1);

  logic [BIT_CNT_W-1:0] bit_q, bit_d;
  logic [BYTE_W-2:0]    rx_sh_q, rx_sh_d;
  logic [BYTE_W-1:0]    rx_byte_q, rx_byte_d;
  logic [BYTE_W-1:0]    tx_sh_q, tx_sh_d;
  logic                 done_q, done_d;

  // a falling edge on a byte boundary loads the next outgoing byte
  assign tx_take = cs_act & sclk_fall & (bit_q == '0);

  always_comb begin
    bit_d     = bit_q;
    rx_sh_d   = rx_sh_q;
    rx_byte_d = rx_byte_q;
    tx_sh_d   = tx_sh_q;
    done_d    = 1'b0;
    if (!cs_act) begin
      bit_d   = '0;
      rx_sh_d = '0;
      tx_sh_d = '0;
    end else begin
      if (sclk_rise) begin
        rx_sh_d = {rx_sh_q[BYTE_W-3:0], mosi_s};
        bit_d   = bit_q + 1'b1;
        if (bit_q == BIT_LAST) begin
          done_d    = 1'b1;
          rx_byte_d = {rx_sh_q, mosi_s};
        end
      end
      if (sclk_fall) begin
        tx_sh_d = tx_take ? tx_byte : {tx_sh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= '0;
      rx_sh_q   <= '0;
      rx_byte_q <= '0;
      tx_sh_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      bit_q     <= bit_d;
      rx_sh_q   <= rx_sh_d;
      rx_byte_q <= rx_byte_d;
      tx_sh_q   <= tx_sh_d;
      done_q    <= done_d;
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rx_byte_q;
  assign miso      = tx_sh_q[BYTE_W-1];
endmodule

// File: rtl/spi_brg_ctrl.sv
module spi_brg_ctrl
  import spi_brg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              tx_take,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_wen,
  output logic              mem_ren,
  input  logic [BYTE_W-1:0] mem_rdata
);
  localparam logic [HDR_IDX_W-1:0] HDR_LAST = HDR_IDX_W'(HDR_BYTES - 1);

  phase_e               phase_q, phase_d;
  logic [HDR_IDX_W-1:0] hidx_q, hidx_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [LEN_W-1:0]     len_q, len_d;
  logic                 wr_q, wr_d;
  logic [BYTE_W-1:0]    rbuf_q, rbuf_d;
  logic                 pend_q, pend_d;
  logic [ADDR_W-1:0]    maddr_q, maddr_d;
  logic [BYTE_W-1:0]    mwdata_q, mwdata_d;
  logic                 mwen_q, mwen_d;
  logic                 mren_q, mren_d;
  logic [LEN_W-1:0]     hdr_len;

  assign hdr_len = {len_q[LEN_W-1:BYTE_W], rx_byte};

  always_comb begin
    phase_d  = phase_q;
    hidx_d   = hidx_q;
    addr_d   = addr_q;
    len_d    = len_q;
    wr_d     = wr_q;
    pend_d   = mren_q;
    rbuf_d   = pend_q ? mem_rdata : rbuf_q;
    maddr_d  = maddr_q;
    mwdata_d = mwdata_q;
    mwen_d   = 1'b0;
    mren_d   = 1'b0;
    if (!cs_act) begin
      phase_d = PH_HDR;
      hidx_d  = '0;
      pend_d  = 1'b0;
    end else begin
      if (byte_done) begin
        unique case (phase_q)
          PH_HDR: begin
            hidx_d = hidx_q + 1'b1;
            unique case (hidx_q)
              2'd0: addr_d[ADDR_W-1:BYTE_W] = rx_byte;
              2'd1: addr_d[BYTE_W-1:0]      = rx_byte;
              2'd2: begin
                wr_d                     = rx_byte[BYTE_W-1];
                len_d[LEN_W-1:BYTE_W]    = rx_byte[LEN_W-BYTE_W-1:0];
              end
              default: len_d[BYTE_W-1:0] = rx_byte;
            endcase
            if (hidx_q == HDR_LAST) begin
              if (hdr_len == '0) begin
                phase_d = PH_DONE;
              end else begin
                phase_d = PH_DATA;
                if (!wr_q) begin
                  mren_d  = 1'b1;
                  maddr_d = addr_q;
                  addr_d  = addr_q + 1'b1;
                end
              end
            end
          end
          PH_DATA: begin
            len_d = len_q - 1'b1;
            if (len_q == LEN_W'(1)) phase_d = PH_DONE;
            if (wr_q) begin
              mwen_d   = 1'b1;
              maddr_d  = addr_q;
              mwdata_d = rx_byte;
              addr_d   = addr_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
      // prefetch the byte after the one now entering the shifter
      if (tx_take && phase_q == PH_DATA && !wr_q && len_q >= LEN_W'(2)) begin
        mren_d  = 1'b1;
        maddr_d = addr_q;
        addr_d  = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_HDR;
      hidx_q   <= '0;
      addr_q   <= '0;
      len_q    <= '0;
      wr_q     <= 1'b0;
      rbuf_q   <= '0;
      pend_q   <= 1'b0;
      maddr_q  <= '0;
      mwdata_q <= '0;
      mwen_q   <= 1'b0;
      mren_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      hidx_q   <= hidx_d;
      addr_q   <= addr_d;
      len_q    <= len_d;
      wr_q     <= wr_d;
      rbuf_q   <= rbuf_d;
      pend_q   <= pend_d;
      maddr_q  <= maddr_d;
      mwdata_q <= mwdata_d;
      mwen_q   <= mwen_d;
      mren_q   <= mren_d;
    end
  end

  assign tx_byte   = (phase_q == PH_DATA && !wr_q) ? rbuf_q : '0;
  assign mem_addr  = maddr_q;
  assign mem_wdata = mwdata_q;
  assign mem_wen   = mwen_q;
  assign mem_ren   = mren_q;
endmodule

// File: rtl/spi_burst_bridge.sv
module spi_burst_bridge
  import spi_brg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_wen,
  output logic              mem_ren,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic [1:0]        rst_pipe;
  logic              rst_n_s;
  logic              sclk_rise, sclk_fall, cs_act, mosi_s;
  logic              tx_take, byte_done;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  // reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  spi_brg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sclk_i    (spi_sclk),
    .cs_n_i    (spi_cs_n),
    .mosi_i    (spi_mosi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .mosi_s    (mosi_s)
  );

  spi_brg_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_act    (cs_act),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_s    (mosi_s),
    .tx_byte   (tx_byte),
    .tx_take   (tx_take),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  spi_brg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_act    (cs_act),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .tx_take   (tx_take),
    .tx_byte   (tx_byte),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wen   (mem_wen),
    .mem_ren   (mem_ren),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: rtl/spi_burst_bridge_chk.sv
module spi_burst_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_act,
  input logic sclk_fall,
  input logic byte_done,
  input logic mem_wen,
  input logic mem_ren,
  input logic spi_miso
);
  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wen && mem_ren));

  // R10
  ren_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ren |=> !mem_ren);

  // R2
  wen_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wen |-> $past(byte_done));

  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso);

  // R9
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !sclk_fall) |=> $stable(spi_miso));
endmodule

bind spi_burst_bridge spi_burst_bridge_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cs_act    (cs_act),
  .sclk_fall (sclk_fall),
  .byte_done (byte_done),
  .mem_wen   (mem_wen),
  .mem_ren   (mem_ren),
  .spi_miso  (spi_miso)
);

// File: tb/spi_burst_bridge_test.sv
`timescale 1ns/1ps
module spi_burst_bridge_test;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_wen, mem_ren;
  logic [7:0]  mem_rdata = 8'h00;

  logic [7:0]  bmem [0:1023];
  logic [7:0]  txb  [0:511];
  logic [7:0]  rxb  [0:511];
  logic [7:0]  hdrx [0:3];
  logic [15:0] wlog [0:511];
  logic [15:0] rlog [0:511];
  int          wn = 0;
  int          rn = 0;
  bit          both_seen = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_burst_bridge uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sclk  (sclk),
    .spi_cs_n  (cs_n),
    .spi_mosi  (mosi),
    .spi_miso  (miso),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wen   (mem_wen),
    .mem_ren   (mem_ren),
    .mem_rdata (mem_rdata)
  );

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 8'(i) ^ 8'h5A;
  end

  always @(posedge clk) begin
    if (mem_wen) bmem[mem_addr[9:0]] <= mem_wdata;
    if (mem_ren) mem_rdata <= bmem[mem_addr[9:0]];
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_wen && mem_ren) both_seen = 1'b1;
      if (mem_wen) begin
        if (wn < 512) wlog[wn] = mem_addr;
        wn++;
      end
      if (mem_ren) begin
        if (rn < 512) rlog[rn] = mem_addr;
        rn++;
      end
    end
  end

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < nb; i++) begin
      mosi = tx[7-i];
      half_wait();
      rx[7-i] = miso;
      sclk = 1'b1;
      half_wait();
      sclk = 1'b0;
    end
  endtask

  // header, n data bytes, optional stray bits, then deselect
  task automatic frame(input logic [15:0] a, input logic wr, input logic [14:0] len,
                       input int n, input int stray);
    logic [7:0] hb [0:3];
    logic [7:0] r;
    hb[0] = a[15:8];
    hb[1] = a[7:0];
    hb[2] = {wr, len[14:8]};
    hb[3] = len[7:0];
    @(negedge clk);
    cs_n = 1'b0;
    half_wait();
    for (int i = 0; i < 4; i++) begin
      xfer(hb[i], 8, r);
      hdrx[i] = r;
    end
    for (int i = 0; i < n; i++) begin
      xfer(txb[i], 8, r);
      rxb[i] = r;
    end
    if (stray > 0) xfer(8'hFF, stray, r);
    half_wait();
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11", "miso after reset", 32'(miso), 0);
    chk("R11", "wen after reset", 32'(mem_wen), 0);
    chk("R11", "ren after reset", 32'(mem_ren), 0);
  endtask

  task automatic t_write_single();
    int w0 = wn;
    txb[0] = 8'hA5;
    frame(16'h0010, 1'b1, 15'd1, 1, 0);
    chk("R2", "single write data", 32'(bmem[16'h10]), 32'h0A5);
    chk("R2", "single write count", 32'(wn - w0), 1);
    chk("R1", "single write address", 32'(wlog[w0]), 32'h0010);
    chk("R2", "neighbour untouched", 32'(bmem[16'h11]), 32'(init_val(16'h11)));
    chk("R9", "miso zero while deselected", 32'(miso), 0);
  endtask

  task automatic t_read16();
    int r0 = rn;
    txb[0] = 8'h00; txb[1] = 8'h00;
    frame(16'h0020, 1'b0, 15'd2, 2, 0);
    chk("R4", "high byte first", 32'(rxb[0]), 32'(init_val(16'h20)));
    chk("R4", "low byte second", 32'(rxb[1]), 32'(init_val(16'h21)));
    chk("R3", "read strobe count", 32'(rn - r0), 2);
    chk("R3", "second fetch address", 32'(rlog[r0 + 1]), 32'h0021);
    chk("R9", "header miso bytes zero",
        32'(hdrx[0] | hdrx[1] | hdrx[2] | hdrx[3]), 0);
  endtask

  task automatic t_long();
    int w0 = wn;
    int r0 = rn;
    int bad = 0;
    for (int i = 0; i < 261; i++) txb[i] = pat(i);
    frame(16'h0100, 1'b1, 15'd261, 261, 0);
    chk("R2", "long write count", 32'(wn - w0), 261);
    chk("R1", "long write last address", 32'(wlog[w0 + 260]), 32'h0204);
    for (int i = 0; i < 261; i++)
      if (bmem[16'h100 + i] !== pat(i)) bad++;
    chk("R2", "long write mismatches", 32'(bad), 0);
    for (int i = 0; i < 261; i++) txb[i] = 8'h00;
    frame(16'h0100, 1'b0, 15'd261, 261, 0);
    chk("R3", "long read strobe count", 32'(rn - r0), 261);
    bad = 0;
    for (int i = 0; i < 261; i++)
      if (rxb[i] !== pat(i)) bad++;
    chk("R3", "long read mismatches", 32'(bad), 0);
    chk("R3", "long read last byte", 32'(rxb[260]), 32'(pat(260)));
  endtask

  task automatic t_wrap();
    int w0 = wn;
    txb[0] = 8'hC1; txb[1] = 8'hC2;
    frame(16'hFFFF, 1'b1, 15'd2, 2, 0);
    chk("R5", "first address", 32'(wlog[w0]), 32'hFFFF);
    chk("R5", "wrapped address", 32'(wlog[w0 + 1]), 32'h0000);
    chk("R5", "wrapped data", 32'(bmem[0]), 32'h0C2);
  endtask

  task automatic t_extra();
    int w0 = wn;
    int r0 = rn;
    txb[0] = 8'hE0; txb[1] = 8'hE1; txb[2] = 8'hE2;
    frame(16'h0030, 1'b1, 15'd1, 3, 0);
    chk("R6", "extra write count", 32'(wn - w0), 1);
    chk("R6", "after-count byte ignored", 32'(bmem[16'h31]), 32'(init_val(16'h31)));
    txb[0] = 8'h00; txb[1] = 8'h00; txb[2] = 8'h00;
    frame(16'h0030, 1'b0, 15'd1, 3, 0);
    chk("R6", "counted read byte", 32'(rxb[0]), 32'h0E0);
    chk("R6", "trailing miso zero", 32'(rxb[1] | rxb[2]), 0);
    chk("R6", "extra read count", 32'(rn - r0), 1);
  endtask

  task automatic t_len0();
    int w0 = wn;
    int r0 = rn;
    txb[0] = 8'h99; txb[1] = 8'h98;
    frame(16'h0040, 1'b1, 15'd0, 2, 0);
    chk("R7", "zero write count", 32'(wn - w0), 0);
    chk("R7", "zero write memory", 32'(bmem[16'h40]), 32'(init_val(16'h40)));
    frame(16'h0041, 1'b0, 15'd0, 2, 0);
    chk("R7", "zero read count", 32'(rn - r0), 0);
    chk("R7", "zero read miso", 32'(rxb[0] | rxb[1]), 0);
  endtask

  task automatic t_abort();
    int w0 = wn;
    txb[0] = 8'hD0; txb[1] = 8'hD1;
    frame(16'h0050, 1'b1, 15'd4, 2, 3);
    chk("R8", "abort write count", 32'(wn - w0), 2);
    chk("R8", "first byte kept", 32'(bmem[16'h50]), 32'h0D0);
    chk("R8", "second byte kept", 32'(bmem[16'h51]), 32'h0D1);
    chk("R8", "partial byte dropped", 32'(bmem[16'h52]), 32'(init_val(16'h52)));
    txb[0] = 8'h00;
    frame(16'h0051, 1'b0, 15'd1, 1, 0);
    chk("R8", "fresh header after abort", 32'(rxb[0]), 32'h0D1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_write_single();
    t_read16();
    t_long();
    t_wrap();
    t_extra();
    t_len0();
    t_abort();
    chk("R10", "strobes never together", 32'(both_seen), 0);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule